// File: doc/BRIEF.md
# Interrupt Context Register Unit

This unit sits beside a processor pipeline and holds the state needed to enter and leave exception handlers. When the pipeline takes an interrupt it signals the class (base, critical or debug) together with the address at which execution must later resume. The unit copies that address and the live machine-state word into a context pair owned by that class, and it clears the class's enable bit in the live machine-state word. When the pipeline later issues the return for a class, the unit hands back the saved resume address in the same cycle and reloads the machine-state word from the saved copy on the next clock edge.

The unit also forms the handler entry address. The upper half comes from a prefix register and the middle bits from one of fifteen offset registers picked by the pipeline's vector index. It records the faulting data address and a syndrome word when the pipeline asks for them. It also holds a process tag, eight scratch words and two read-only identity words. Software reaches every register through a single-cycle register-number port. Reads are combinational. A write takes effect at the next clock edge.

All pins are plain control and status signals. No interface carries streamed data, so the unit has no valid/ready handshake and applies no back-pressure.

Top module: `exc_ctx_regs`

## Requirements
- R1: A take with class 0 loads the base context pair (resume word at register 0x08, state word at 0x09) from `exc_resume_pc` and the pre-entry `msr_out`. In the same edge it clears bit 15 of the machine-state word.
- R2: A take with class 1 loads the critical pair (0x0A resume, 0x0B state) the same way and clears machine-state bit 17.
- R3: A take with class 2 loads the debug pair (0x0C resume, 0x0D state) the same way and clears machine-state bit 9.
- R4: While `ret_valid` is high with class c in 0..2, `redirect_valid` is 1 and `redirect_addr` equals the resume word of pair c, in the same cycle. At the next edge, `msr_out` becomes the state word of pair c.
- R5: `handler_addr` is combinational. It is formed from prefix bits [31:16] (register 0x06), then bits [15:4] of offset register 0x20+idx (idx 0..14), then four zero bits. Index 15 contributes a zero offset. The prefix reads back with its low half zero, and an offset reads back with only bits [15:4] kept.
- R6: On a take with `exc_dear_load` high, register 0x04 loads `exc_fault_addr`. On a take with `exc_esr_load` high, register 0x05 loads `exc_syndrome`.
- R7: Register 0x01 always reads 0x8112_0000 and register 0x02 always reads the PROC_ID parameter (default 0). Writes to either, or to any unmapped number such as 0x3F, have no effect, and unmapped numbers read 0.
- R8: Scratch registers 0x10..0x17 and the machine-state word 0x00 read back what was written. The process tag at 0x03 keeps only its low PID_W bits (default 8).
- R9: A take overrides a software write to a register it loads in the same cycle. A return overrides a software write to the machine-state word in the same cycle.
- R10: A take and a return in the same cycle: the take is performed, `redirect_valid` stays 0 and the return is dropped. A class code of 3 on either a take or a return has no effect.
- R11: After reset, `msr_out` equals MSR_RST (default 0), `redirect_valid` is 0 and every writable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_take | input | 1 | Interrupt entry strobe |
| exc_class | input | 2 | Entry class: 0 base, 1 critical, 2 debug, 3 none |
| exc_vec_idx | input | 4 | Offset register index for handler address |
| exc_resume_pc | input | 32 | Resume address to save on entry |
| exc_dear_load | input | 1 | Capture fault address with this entry |
| exc_fault_addr | input | 32 | Faulting data address |
| exc_esr_load | input | 1 | Capture syndrome with this entry |
| exc_syndrome | input | 32 | Syndrome word |
| handler_addr | output | 32 | Computed handler entry address |
| ret_valid | input | 1 | Return-from-handler strobe |
| ret_class | input | 2 | Return class, same encoding as entry |
| redirect_valid | output | 1 | Resume address is being supplied |
| redirect_addr | output | 32 | Resume address for the return |
| msr_out | output | 32 | Live machine-state word |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 6 | Software register number |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data (combinational) |

## Verification
Two pairs of events can land in the same clock cycle. The first is an interrupt entry and a software write aimed at a register the entry loads. The second is an entry and a return. The bench drives a base-class entry together with a software write to the base resume register, and a return together with a software write to the machine-state word; it then reads both registers back through the software port and expects the hardware values. It also raises an entry and a return on the same edge and judges the outcome by `redirect_valid` staying low, the machine-state word losing only the entering class's enable bit, and the entering class's pair holding the new context.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;
  localparam int XLEN    = 32;
  localparam int ADDR_W  = 6;
  localparam int NUM_CLS = 3;

  typedef enum logic [1:0] {
    CLS_BASE = 2'd0,
    CLS_CRIT = 2'd1,
    CLS_DBG  = 2'd2,
    CLS_NONE = 2'd3
  } exc_cls_e;

  localparam logic [ADDR_W-1:0] RA_MSR       = 6'h00;
  localparam logic [ADDR_W-1:0] RA_VERSION   = 6'h01;
  localparam logic [ADDR_W-1:0] RA_CORE_ID   = 6'h02;
  localparam logic [ADDR_W-1:0] RA_PTAG      = 6'h03;
  localparam logic [ADDR_W-1:0] RA_FAULT     = 6'h04;
  localparam logic [ADDR_W-1:0] RA_SYND      = 6'h05;
  localparam logic [ADDR_W-1:0] RA_VPFX      = 6'h06;
  localparam logic [ADDR_W-1:0] RA_SAVE_BASE = 6'h08;
  localparam logic [ADDR_W-1:0] RA_SCR_BASE  = 6'h10;
  localparam logic [ADDR_W-1:0] RA_OFS_BASE  = 6'h20;

  localparam int EE_POS = 15;
  localparam int CE_POS = 17;
  localparam int DE_POS = 9;

  localparam logic [XLEN-1:0] VERSION_WORD = 32'h8112_0000;

  // enable bit owned by each class in the machine-state word
  function automatic logic [XLEN-1:0] cls_enable_mask(input logic [1:0] cls);
    logic [XLEN-1:0] m;
    m = '0;
    case (cls)
      CLS_BASE: m[EE_POS] = 1'b1;
      CLS_CRIT: m[CE_POS] = 1'b1;
      CLS_DBG:  m[DE_POS] = 1'b1;
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_save,
  input  logic [W-1:0] save_pc,
  input  logic [W-1:0] save_msr,
  input  logic         sw_we0,
  input  logic         sw_we1,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] ctx0_q,
  output logic [W-1:0] ctx1_q
);
  // hardware capture has priority over the software port (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx0_q <= '0;
      ctx1_q <= '0;
    end else if (hw_save) begin
      ctx0_q <= save_pc;
      ctx1_q <= save_msr;
    end else begin
      if (sw_we0) ctx0_q <= sw_wdata;
      if (sw_we1) ctx1_q <= sw_wdata;
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_ctx_pkg::*;
#(
  parameter int NUM_OFS = 15,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [XLEN-1:4]   sw_wdata,
  input  logic [IDX_W-1:0]  vec_idx,
  output logic [XLEN-1:0]   handler_addr,
  output logic [XLEN-1:0]   rd_data
);
  localparam int HALF_W = XLEN / 2;
  localparam int OFS_W  = HALF_W - 4;

  logic [HALF_W-1:0] pfx_q;
  logic [OFS_W-1:0]  ofs_q [NUM_OFS];
  logic [OFS_W-1:0]  ofs_sel;
  logic [XLEN-1:0]   ofs_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pfx_q <= '0;
    else if (sw_wr && sw_addr == RA_VPFX) pfx_q <= sw_wdata[XLEN-1:HALF_W];
  end

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_ofs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ofs_q[i] <= '0;
      else if (sw_wr && sw_addr == RA_OFS_BASE + ADDR_W'(i))
        ofs_q[i] <= sw_wdata[HALF_W-1:4];
    end
  end

  always_comb begin
    ofs_sel = '0;
    for (int i = 0; i < NUM_OFS; i++)
      if (vec_idx == IDX_W'(i)) ofs_sel = ofs_q[i];
  end

  always_comb begin
    ofs_rd = '0;
    for (int i = 0; i < NUM_OFS; i++)
      if (sw_addr == RA_OFS_BASE + ADDR_W'(i))
        ofs_rd = {{HALF_W{1'b0}}, ofs_q[i], 4'h0};
  end

  assign handler_addr = {pfx_q, ofs_sel, 4'h0};
  assign rd_data = ((sw_addr == RA_VPFX) ? {pfx_q, {HALF_W{1'b0}}} : '0) | ofs_rd;
endmodule

// File: rtl/exc_misc_regs.sv
module exc_misc_regs
  import exc_ctx_pkg::*;
#(
  parameter int NUM_SCR = 8,
  parameter int PID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [XLEN-1:0]   sw_wdata,
  input  logic              fault_ld,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic              synd_ld,
  input  logic [XLEN-1:0]   syndrome,
  output logic [XLEN-1:0]   fault_q,
  output logic [XLEN-1:0]   rd_data
);
  logic [XLEN-1:0]  synd_q;
  logic [PID_W-1:0] ptag_q;
  logic [XLEN-1:0]  scr_q [NUM_SCR];
  logic [XLEN-1:0]  scr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            fault_q <= '0;
    else if (fault_ld)                     fault_q <= fault_addr;
    else if (sw_wr && sw_addr == RA_FAULT) fault_q <= sw_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           synd_q <= '0;
    else if (synd_ld)                     synd_q <= syndrome;
    else if (sw_wr && sw_addr == RA_SYND) synd_q <= sw_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ptag_q <= '0;
    else if (sw_wr && sw_addr == RA_PTAG) ptag_q <= sw_wdata[PID_W-1:0];
  end

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        scr_q[i] <= '0;
      else if (sw_wr && sw_addr == RA_SCR_BASE + ADDR_W'(i))
        scr_q[i] <= sw_wdata;
    end
  end

  always_comb begin
    scr_rd = '0;
    for (int i = 0; i < NUM_SCR; i++)
      if (sw_addr == RA_SCR_BASE + ADDR_W'(i)) scr_rd = scr_q[i];
  end

  always_comb begin
    rd_data = scr_rd;
    case (sw_addr)
      RA_FAULT: rd_data = fault_q;
      RA_SYND:  rd_data = synd_q;
      RA_PTAG:  rd_data = {{(XLEN-PID_W){1'b0}}, ptag_q};
      default:  ;
    endcase
  end
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_ctx_pkg::*;
#(
  parameter logic [XLEN-1:0] PROC_ID = '0,
  parameter int              PID_W   = 8,
  parameter int              NUM_SCR = 8,
  parameter int              NUM_OFS = 15,
  parameter logic [XLEN-1:0] MSR_RST = '0,
  localparam int             VIDX_W  = $clog2(NUM_OFS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [1:0]        exc_class,
  input  logic [VIDX_W-1:0] exc_vec_idx,
  input  logic [XLEN-1:0]   exc_resume_pc,
  input  logic              exc_dear_load,
  input  logic [XLEN-1:0]   exc_fault_addr,
  input  logic              exc_esr_load,
  input  logic [XLEN-1:0]   exc_syndrome,
  output logic [XLEN-1:0]   handler_addr,
  input  logic              ret_valid,
  input  logic [1:0]        ret_class,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_addr,
  output logic [XLEN-1:0]   msr_out,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [XLEN-1:0]   sw_wdata,
  output logic [XLEN-1:0]   sw_rdata
);
  localparam int FLAT_W = NUM_CLS * XLEN;

  logic              take_ok;
  logic              ret_ok;
  logic [XLEN-1:0]   msr_q;
  logic [FLAT_W-1:0] save0_flat;
  logic [FLAT_W-1:0] save1_flat;
  logic [XLEN-1:0]   ret_pc;
  logic [XLEN-1:0]   ret_msr;
  logic [XLEN-1:0]   save_rd;
  logic [XLEN-1:0]   core_rd;
  logic [XLEN-1:0]   misc_rd;
  logic [XLEN-1:0]   vec_rd;
  logic [XLEN-1:0]   dear_q;

  // class 3 is inert; an entry drops a return in the same cycle (R10)
  assign take_ok = exc_take && (exc_class != CLS_NONE);
  assign ret_ok  = ret_valid && (ret_class != CLS_NONE) && !take_ok;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
    exc_save_bank #(.W(XLEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_save  (take_ok && exc_class == 2'(c)),
      .save_pc  (exc_resume_pc),
      .save_msr (msr_q),
      .sw_we0   (sw_wr && sw_addr == RA_SAVE_BASE + ADDR_W'(2 * c)),
      .sw_we1   (sw_wr && sw_addr == RA_SAVE_BASE + ADDR_W'(2 * c + 1)),
      .sw_wdata (sw_wdata),
      .ctx0_q   (save0_flat[c*XLEN +: XLEN]),
      .ctx1_q   (save1_flat[c*XLEN +: XLEN])
    );
  end

  always_comb begin
    ret_pc  = '0;
    ret_msr = '0;
    for (int c = 0; c < NUM_CLS; c++)
      if (ret_class == 2'(c)) begin
        ret_pc  = save0_flat[c*XLEN +: XLEN];
        ret_msr = save1_flat[c*XLEN +: XLEN];
      end
  end

  // machine-state word: entry, then return, then software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          msr_q <= MSR_RST;
    else if (take_ok)                    msr_q <= msr_q & ~cls_enable_mask(exc_class);
    else if (ret_ok)                     msr_q <= ret_msr;
    else if (sw_wr && sw_addr == RA_MSR) msr_q <= sw_wdata;
  end

  assign msr_out        = msr_q;
  assign redirect_valid = ret_ok;
  assign redirect_addr  = ret_ok ? ret_pc : '0;

  exc_vector_gen #(.NUM_OFS(NUM_OFS), .IDX_W(VIDX_W)) u_vec (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_wr        (sw_wr),
    .sw_addr      (sw_addr),
    .sw_wdata     (sw_wdata[XLEN-1:4]),
    .vec_idx      (exc_vec_idx),
    .handler_addr (handler_addr),
    .rd_data      (vec_rd)
  );

  exc_misc_regs #(.NUM_SCR(NUM_SCR), .PID_W(PID_W)) u_misc (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr      (sw_wr),
    .sw_addr    (sw_addr),
    .sw_wdata   (sw_wdata),
    .fault_ld   (take_ok && exc_dear_load),
    .fault_addr (exc_fault_addr),
    .synd_ld    (take_ok && exc_esr_load),
    .syndrome   (exc_syndrome),
    .fault_q    (dear_q),
    .rd_data    (misc_rd)
  );

  always_comb begin
    save_rd = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (sw_addr == RA_SAVE_BASE + ADDR_W'(2 * c))     save_rd = save0_flat[c*XLEN +: XLEN];
      if (sw_addr == RA_SAVE_BASE + ADDR_W'(2 * c + 1)) save_rd = save1_flat[c*XLEN +: XLEN];
    end
  end

  always_comb begin
    case (sw_addr)
      RA_MSR:     core_rd = msr_q;
      RA_VERSION: core_rd = VERSION_WORD;
      RA_CORE_ID: core_rd = PROC_ID;
      default:    core_rd = '0;
    endcase
  end

  assign sw_rdata = core_rd | save_rd | misc_rd | vec_rd;
endmodule

// File: rtl/exc_ctx_regs_chk.sv
module exc_ctx_regs_chk
  import exc_ctx_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      exc_take,
  input logic [1:0]                exc_class,
  input logic [XLEN-1:0]           exc_resume_pc,
  input logic                      exc_dear_load,
  input logic [XLEN-1:0]           exc_fault_addr,
  input logic                      ret_valid,
  input logic [1:0]                ret_class,
  input logic                      redirect_valid,
  input logic [XLEN-1:0]           msr_out,
  input logic [NUM_CLS*XLEN-1:0]   save0_flat,
  input logic [NUM_CLS*XLEN-1:0]   save1_flat,
  input logic [XLEN-1:0]           dear_q
);
  logic            take_any;
  logic            ret_live;
  logic [XLEN-1:0] ret_src;

  assign take_any = exc_take && exc_class != 2'd3;
  assign ret_live = ret_valid && ret_class != 2'd3 && !take_any;

  always_comb begin
    case (ret_class)
      2'd0:    ret_src = save1_flat[0*XLEN +: XLEN];
      2'd1:    ret_src = save1_flat[1*XLEN +: XLEN];
      2'd2:    ret_src = save1_flat[2*XLEN +: XLEN];
      default: ret_src = '0;
    endcase
  end

  p_base_save_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_class == 2'd0 |=>
      save0_flat[0*XLEN +: XLEN] == $past(exc_resume_pc) &&
      save1_flat[0*XLEN +: XLEN] == $past(msr_out) && !msr_out[EE_POS]);

  p_crit_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_class == 2'd1 |=>
      save0_flat[1*XLEN +: XLEN] == $past(exc_resume_pc) &&
      save1_flat[1*XLEN +: XLEN] == $past(msr_out) && !msr_out[CE_POS]);

  p_dbg_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_class == 2'd2 |=>
      save0_flat[2*XLEN +: XLEN] == $past(exc_resume_pc) &&
      save1_flat[2*XLEN +: XLEN] == $past(msr_out) && !msr_out[DE_POS]);

  p_ret_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_live |=> msr_out == $past(ret_src));

  p_fault_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_any && exc_dear_load |=> dear_q == $past(exc_fault_addr));

  p_take_over_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_any && ret_valid |-> !redirect_valid);

  p_none_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_class == 2'd3 && !ret_valid && !$past(!rst_n) |=> $stable(save0_flat));
endmodule

bind exc_ctx_regs exc_ctx_regs_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .exc_take       (exc_take),
  .exc_class      (exc_class),
  .exc_resume_pc  (exc_resume_pc),
  .exc_dear_load  (exc_dear_load),
  .exc_fault_addr (exc_fault_addr),
  .ret_valid      (ret_valid),
  .ret_class      (ret_class),
  .redirect_valid (redirect_valid),
  .msr_out        (msr_out),
  .save0_flat     (save0_flat),
  .save1_flat     (save1_flat),
  .dear_q         (dear_q)
);

// File: tb/test_exc_ctx_regs.sv
`timescale 1ns/1ps
module test_exc_ctx_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_take = 1'b0;
  logic [1:0]  exc_class = 2'd0;
  logic [3:0]  exc_vec_idx = 4'd0;
  logic [31:0] exc_resume_pc = '0;
  logic        exc_dear_load = 1'b0;
  logic [31:0] exc_fault_addr = '0;
  logic        exc_esr_load = 1'b0;
  logic [31:0] exc_syndrome = '0;
  logic [31:0] handler_addr;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_class = 2'd0;
  logic        redirect_valid;
  logic [31:0] redirect_addr;
  logic [31:0] msr_out;
  logic        sw_wr = 1'b0;
  logic [5:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_ctx_regs i_exc_ctx_regs (
    .clk(clk), .rst_n(rst_n),
    .exc_take(exc_take), .exc_class(exc_class), .exc_vec_idx(exc_vec_idx),
    .exc_resume_pc(exc_resume_pc), .exc_dear_load(exc_dear_load),
    .exc_fault_addr(exc_fault_addr), .exc_esr_load(exc_esr_load),
    .exc_syndrome(exc_syndrome), .handler_addr(handler_addr),
    .ret_valid(ret_valid), .ret_class(ret_class),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .msr_out(msr_out), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  // {op: 1 write / 2 read-compare, register number, write data, expected}
  localparam int NV = 17;
  localparam logic [71:0] VTAB [NV] = '{
    {2'd1, 6'h03, 32'hABCD_1234, 32'h0},          // R8 process tag
    {2'd2, 6'h03, 32'h0,         32'h0000_0034},  // R8 low bits kept
    {2'd1, 6'h10, 32'h1111_1111, 32'h0},          // R8 scratch 0
    {2'd1, 6'h17, 32'hDEAD_BEEF, 32'h0},          // R8 scratch 7
    {2'd2, 6'h10, 32'h0,         32'h1111_1111},  // R8
    {2'd2, 6'h17, 32'h0,         32'hDEAD_BEEF},  // R8
    {2'd1, 6'h01, 32'h0,         32'h0},          // R7 write to version
    {2'd2, 6'h01, 32'h0,         32'h8112_0000},  // R7
    {2'd1, 6'h02, 32'h0000_0005, 32'h0},          // R7 write to core id
    {2'd2, 6'h02, 32'h0,         32'h0},          // R7
    {2'd1, 6'h3F, 32'h0000_1234, 32'h0},          // R7 unmapped
    {2'd2, 6'h3F, 32'h0,         32'h0},          // R7
    {2'd1, 6'h06, 32'h1234_5678, 32'h0},          // R5 prefix
    {2'd2, 6'h06, 32'h0,         32'h1234_0000},  // R5
    {2'd1, 6'h23, 32'hFFFF_FFFF, 32'h0},          // R5 offset 3
    {2'd2, 6'h23, 32'h0,         32'h0000_FFF0},  // R5
    {2'd1, 6'h00, 32'hFFFF_FFFF, 32'h0}           // R8 machine-state word
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_addr = a; sw_wdata = d; sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic sw_read(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    sw_addr = a;
    #1 v = sw_rdata;
  endtask

  task automatic take_exc(input logic [1:0] c, input logic [31:0] pc);
    @(negedge clk);
    exc_take = 1'b1; exc_class = c; exc_resume_pc = pc;
    @(negedge clk);
    exc_take = 1'b0;
  endtask

  task automatic do_ret(input string req, input logic [1:0] c, input logic rv_exp,
                        input logic [31:0] ra_exp, input logic [31:0] msr_exp);
    @(negedge clk);
    ret_valid = 1'b1; ret_class = c;
    #1;
    check(req, {31'd0, redirect_valid}, {31'd0, rv_exp});
    check(req, redirect_addr, ra_exp);
    @(negedge clk);
    ret_valid = 1'b0;
    check(req, msr_out, msr_exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    #1;
    check("R11 msr", msr_out, 32'h0);
    check("R11 redirect", {31'd0, redirect_valid}, 32'h0);
    sw_read(6'h08, v); check("R11 save0", v, 32'h0);
    sw_read(6'h04, v); check("R11 fault", v, 32'h0);
    sw_read(6'h14, v); check("R11 scratch", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VTAB[i][71:70] == 2'd1) sw_write(VTAB[i][69:64], VTAB[i][63:32]);
      else begin
        sw_read(VTAB[i][69:64], v);
        check($sformatf("table row %0d", i), v, VTAB[i][31:0]);
      end
    end
    sw_read(6'h00, v); check("R8 msr readback", v, 32'hFFFF_FFFF);

    // R5 handler address
    @(negedge clk); exc_vec_idx = 4'd3; #1;
    check("R5 idx3", handler_addr, 32'h1234_FFF0);
    @(negedge clk); exc_vec_idx = 4'd15; #1;
    check("R5 idx15", handler_addr, 32'h1234_0000);

    // R1 + R6 base entry with fault and syndrome capture
    exc_dear_load = 1'b1; exc_fault_addr = 32'hCAFE_0003;
    exc_esr_load = 1'b1; exc_syndrome = 32'h0080_0000;
    take_exc(2'd0, 32'h1000_0040);
    exc_dear_load = 1'b0; exc_esr_load = 1'b0;
    check("R1 msr", msr_out, 32'hFFFF_7FFF);
    sw_read(6'h08, v); check("R1 resume", v, 32'h1000_0040);
    sw_read(6'h09, v); check("R1 state", v, 32'hFFFF_FFFF);
    sw_read(6'h04, v); check("R6 fault", v, 32'hCAFE_0003);
    sw_read(6'h05, v); check("R6 syndrome", v, 32'h0080_0000);

    // R2 critical entry
    take_exc(2'd1, 32'h2000_0100);
    check("R2 msr", msr_out, 32'hFFFD_7FFF);
    sw_read(6'h0A, v); check("R2 resume", v, 32'h2000_0100);
    sw_read(6'h0B, v); check("R2 state", v, 32'hFFFF_7FFF);
    sw_read(6'h04, v); check("R6 fault held", v, 32'hCAFE_0003);

    // R3 debug entry
    take_exc(2'd2, 32'h3000_0200);
    check("R3 msr", msr_out, 32'hFFFD_7DFF);
    sw_read(6'h0C, v); check("R3 resume", v, 32'h3000_0200);
    sw_read(6'h0D, v); check("R3 state", v, 32'hFFFD_7FFF);

    // R4 unwinding returns
    do_ret("R4 debug", 2'd2, 1'b1, 32'h3000_0200, 32'hFFFD_7FFF);
    do_ret("R4 crit",  2'd1, 1'b1, 32'h2000_0100, 32'hFFFF_7FFF);
    do_ret("R4 base",  2'd0, 1'b1, 32'h1000_0040, 32'hFFFF_FFFF);

    // R10 class 3 inert
    take_exc(2'd3, 32'h7777_0000);
    check("R10 none take msr", msr_out, 32'hFFFF_FFFF);
    sw_read(6'h08, v); check("R10 none take save", v, 32'h1000_0040);
    do_ret("R10 none ret", 2'd3, 1'b0, 32'h0, 32'hFFFF_FFFF);

    // R9 entry vs software write to its resume register
    @(negedge clk);
    exc_take = 1'b1; exc_class = 2'd0; exc_resume_pc = 32'h4000_0000;
    sw_wr = 1'b1; sw_addr = 6'h08; sw_wdata = 32'h5555_5555;
    @(negedge clk);
    exc_take = 1'b0; sw_wr = 1'b0;
    sw_read(6'h08, v); check("R9 take wins", v, 32'h4000_0000);
    check("R9 msr after take", msr_out, 32'hFFFF_7FFF);

    // R9 return vs software write to machine-state word
    @(negedge clk);
    ret_valid = 1'b1; ret_class = 2'd0;
    sw_wr = 1'b1; sw_addr = 6'h00; sw_wdata = 32'h0;
    #1 check("R9 redirect", redirect_addr, 32'h4000_0000);
    @(negedge clk);
    ret_valid = 1'b0; sw_wr = 1'b0;
    check("R9 return wins", msr_out, 32'hFFFF_FFFF);

    // R10 entry and return on one edge
    @(negedge clk);
    exc_take = 1'b1; exc_class = 2'd1; exc_resume_pc = 32'h6000_0000;
    ret_valid = 1'b1; ret_class = 2'd0;
    #1 check("R10 no redirect", {31'd0, redirect_valid}, 32'h0);
    @(negedge clk);
    exc_take = 1'b0; ret_valid = 1'b0;
    check("R10 msr", msr_out, 32'hFFFD_FFFF);
    sw_read(6'h0A, v); check("R10 crit resume", v, 32'h6000_0000);
    sw_read(6'h0B, v); check("R10 crit state", v, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule